// File: doc/BRIEF.md
# pi/4 DQPSK Symbol Mapper

This block turns a stream of host-supplied transmit data words into pi/4 DQPSK constellation points. Words enter a four-deep buffer through a simple write port. At every pulse of a symbol-rate strobe the block takes the next two bits and turns them into a phase step. It adds the step to a running phase, held as an index counted in pi/4 steps. It then drives the cosine and sine of the new phase as signed I and Q samples, with a one-cycle valid pulse.

The strobe sets the symbol rate, so the same block serves any rate that the surrounding clock divider produces. A bypass mode hands the output to the host, which then writes I/Q pairs straight through for other modulation schemes. While bypass is active, the running phase and the buffered data are left untouched. Sticky flags report a write that was dropped because the buffer was full. They also report a strobe that found no data, in which case the block repeats the current point.

Top module: `dqpsk_mapper`

## Requirements
- R1: After reset, out_i and out_q are 0, out_vld is 0, fifo_empty is 1, fifo_full, ovf_flag and unf_flag are 0, and the phase index is 0, so a first dibit 00 produces point index 1.
- R2: Each 16-bit word supplies 8 dibits, starting with bits [15:14] and ending with bits [1:0]. The word leaves the buffer when its eighth dibit is used.
- R3: The phase index advances modulo 8 by the dibit's step: 00 adds 1, 01 adds 3, 10 adds 7 (that is, -1), 11 adds 5 (that is, -3).
- R4: Point index k has angle k*pi/4. Even indices give (23170,0), (0,23170), (-23170,0) and (0,-23170) for k = 0, 2, 4, 6. Odd indices give the same signs with magnitude 16383 on both rails.
- R5: With bypass low, a strobe updates out_i and out_q and pulses out_vld on the next clock edge. out_vld is high for exactly one cycle per strobe.
- R6: The buffer holds 4 words. fifo_full is high at 4 words and fifo_empty is high at 0.
- R7: A write while fifo_full is high is dropped (even if a strobe frees an entry in the same cycle) and sets ovf_flag, which stays set until reset.
- R8: A strobe with an empty buffer leaves the phase unchanged, outputs the current point again with out_vld, and sets unf_flag, which stays set until reset.
- R9: With bypass high, byp_wr loads byp_i and byp_q onto out_i and out_q, and pulses out_vld, on the next edge.
- R10: With bypass high, strobes produce no output and no underflow, consume no data and leave the phase unchanged.
- R11: With bypass low, byp_wr has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one data word into the buffer |
| wr_data | input | 16 | Data word, first dibit in the top bits |
| sym_stb | input | 1 | Symbol-rate strobe, one cycle per symbol |
| bypass | input | 1 | 1 = host drives I/Q directly |
| byp_wr | input | 1 | Direct I/Q write strobe |
| byp_i | input | 16 | Direct I sample |
| byp_q | input | 16 | Direct Q sample |
| out_i | output | 16 | Signed I sample |
| out_q | output | 16 | Signed Q sample |
| out_vld | output | 1 | One-cycle pulse on a new I/Q pair |
| fifo_full | output | 1 | Buffer holds 4 words |
| fifo_empty | output | 1 | Buffer holds no word |
| ovf_flag | output | 1 | Sticky: a write was dropped |
| unf_flag | output | 1 | Sticky: a strobe found no data |

## Verification
The bench builds the block with its defaults: 16-bit words, a 4-word buffer and a 16-bit sample with axis amplitude 23170. These defaults let the bench fill the buffer with only four writes and reach the dropped-write case with the fifth. With 8 dibits per word, a short run of strobes crosses word boundaries and drains the buffer into the underflow repeat. Eight-point phase wrap-around is reached within a single word, because patterns of mixed dibits step the index past 7 in both directions.

// File: rtl/dqpsk_pkg.sv
// Shared types and the dibit-to-phase-step rule for the pi/4 DQPSK mapper.
package dqpsk_pkg;

    // Phase held as a count of pi/4 steps, modulo 8.
    typedef logic [2:0] phase_t;

    // Phase step for one dibit, in pi/4 units modulo 8.
    function automatic phase_t dibit_step(input logic [1:0] d);
        case (d)
            2'b00:   return 3'd1;
            2'b01:   return 3'd3;
            2'b10:   return 3'd7;
            default: return 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/dqpsk_fifo.sv
// Word buffer for transmit data.
// Assumes DEPTH is a power of two. A write while full is dropped, even if a
// pop happens in the same cycle, and sets a sticky overflow flag.
module dqpsk_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              full,
    output logic              empty,
    output logic              ovf
);
    localparam int AW = $clog2(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [AW:0]       count;
    logic              push;

    assign full  = (count == (AW+1)'(DEPTH));
    assign empty = (count == '0);
    assign push  = push_req && !full;
    assign head  = mem[rptr];

    // One storage register per entry, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push && wptr == AW'(g))
                mem[g] <= push_data;
        end
    end

    // Pointer, occupancy and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push)
                wptr <= wptr + 1'b1;
            if (pop)
                rptr <= rptr + 1'b1;
            if (push && !pop)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
            if (push_req && full)
                ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/dqpsk_sym_ctrl.sv
// Symbol sequencer: picks dibits from the buffer head, MSB pair first,
// keeps the running phase and the underflow flag.
// Assumes the caller gates sym_fire with bypass and that WORD_W/2 is a power
// of two, so the dibit index wraps by itself.
module dqpsk_sym_ctrl
    import dqpsk_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_fire,
    input  logic              empty,
    input  logic [WORD_W-1:0] head,
    output logic              pop,
    output phase_t            ph_sel,
    output logic              unf
);
    localparam int NDIB = WORD_W / 2;
    localparam int IW   = $clog2(NDIB);

    logic [IW-1:0]     idx;
    phase_t            ph;
    logic [WORD_W-1:0] shifted;
    logic [1:0]        dibit;

    // Select the current dibit by shifting it up to the top of the word.
    always_comb begin
        shifted = head << {idx, 1'b0};
        dibit   = shifted[WORD_W-1 -: 2];
    end

    assign ph_sel = empty ? ph : ph + dibit_step(dibit);
    assign pop    = sym_fire && !empty && (idx == IW'(NDIB-1));

    // Advance phase and dibit index per symbol; latch underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= '0;
            idx <= '0;
            unf <= 1'b0;
        end else if (sym_fire) begin
            if (empty) begin
                unf <= 1'b1;
            end else begin
                ph  <= ph_sel;
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dqpsk_point_lut.sv
// Constellation table: phase index k -> (cos, sin) of k*pi/4 at amplitude AMP.
// Assumes AMP fits in SAMP_W-1 magnitude bits. The diagonal value is AMP*cos(pi/4).
module dqpsk_point_lut
    import dqpsk_pkg::*;
#(
    parameter int SAMP_W = 16,
    parameter int AMP    = 23170
) (
    input  phase_t                   ph,
    output logic signed [SAMP_W-1:0] pt_i,
    output logic signed [SAMP_W-1:0] pt_q
);
    localparam int DIAG = int'((longint'(AMP) * 46341) >>> 16);
    localparam logic signed [SAMP_W-1:0] A = SAMP_W'(AMP);
    localparam logic signed [SAMP_W-1:0] D = SAMP_W'(DIAG);

    // Map the eight phase indices to signed rail values.
    always_comb begin
        case (ph)
            3'd0:    begin pt_i = A;  pt_q = '0; end
            3'd1:    begin pt_i = D;  pt_q = D;  end
            3'd2:    begin pt_i = '0; pt_q = A;  end
            3'd3:    begin pt_i = -D; pt_q = D;  end
            3'd4:    begin pt_i = -A; pt_q = '0; end
            3'd5:    begin pt_i = -D; pt_q = -D; end
            3'd6:    begin pt_i = '0; pt_q = -A; end
            default: begin pt_i = D;  pt_q = -D; end
        endcase
    end
endmodule

// File: rtl/dqpsk_mapper.sv
// pi/4 DQPSK symbol mapper top: buffer, sequencer, point table and output
// register, with a bypass path for host-written I/Q.
// Assumes sym_stb is a one-cycle pulse at the symbol rate.
module dqpsk_mapper #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4,
    parameter int SAMP_W = 16,
    parameter int AMP    = 23170
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     sym_stb,
    input  logic                     bypass,
    input  logic                     byp_wr,
    input  logic signed [SAMP_W-1:0] byp_i,
    input  logic signed [SAMP_W-1:0] byp_q,
    output logic signed [SAMP_W-1:0] out_i,
    output logic signed [SAMP_W-1:0] out_q,
    output logic                     out_vld,
    output logic                     fifo_full,
    output logic                     fifo_empty,
    output logic                     ovf_flag,
    output logic                     unf_flag
);
    import dqpsk_pkg::*;

    logic                     sym_fire, byp_load, pop;
    logic [WORD_W-1:0]        head;
    phase_t                   ph_sel;
    logic signed [SAMP_W-1:0] pt_i, pt_q;

    assign sym_fire = sym_stb && !bypass;
    assign byp_load = byp_wr && bypass;

    dqpsk_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_req(wr_en), .push_data(wr_data),
        .pop(pop), .head(head), .full(fifo_full), .empty(fifo_empty),
        .ovf(ovf_flag)
    );

    dqpsk_sym_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sym_fire(sym_fire), .empty(fifo_empty),
        .head(head), .pop(pop), .ph_sel(ph_sel), .unf(unf_flag)
    );

    dqpsk_point_lut #(.SAMP_W(SAMP_W), .AMP(AMP)) u_lut (
        .ph(ph_sel), .pt_i(pt_i), .pt_q(pt_q)
    );

    // Output register: bypass write or modulated point, plus valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_i   <= '0;
            out_q   <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= byp_load || sym_fire;
            if (byp_load) begin
                out_i <= byp_i;
                out_q <= byp_q;
            end else if (sym_fire) begin
                out_i <= pt_i;
                out_q <= pt_q;
            end
        end
    end
endmodule

// File: rtl/dqpsk_mapper_chk.sv
// Protocol checker for dqpsk_mapper, attached by bind below.
// Assumes the reset is synchronous and active low.
module dqpsk_mapper_chk #(
    parameter int SAMP_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic                     sym_stb,
    input logic                     bypass,
    input logic                     byp_wr,
    input logic signed [SAMP_W-1:0] byp_i,
    input logic signed [SAMP_W-1:0] byp_q,
    input logic signed [SAMP_W-1:0] out_i,
    input logic signed [SAMP_W-1:0] out_q,
    input logic                     out_vld,
    input logic                     fifo_full,
    input logic                     fifo_empty,
    input logic                     ovf_flag,
    input logic                     unf_flag
);
    p_full_empty_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    p_ovf_on_full_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_full) |=> ovf_flag);

    p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag);

    p_unf_on_empty_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && !bypass && fifo_empty) |=> unf_flag);

    p_vld_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past((sym_stb && !bypass) || (byp_wr && bypass)));

    p_mod_point_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(rst_n && sym_stb && !bypass)) |-> (out_i != '0 || out_q != '0));

    p_bypass_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && byp_wr && bypass) |-> (out_i == $past(byp_i) && out_q == $past(byp_q)));

    p_bypass_no_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && bypass && !wr_en) |=> $stable(fifo_empty) && $stable(unf_flag));
endmodule

bind dqpsk_mapper dqpsk_mapper_chk #(.SAMP_W(SAMP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sym_stb(sym_stb), .bypass(bypass),
    .byp_wr(byp_wr), .byp_i(byp_i), .byp_q(byp_q), .out_i(out_i), .out_q(out_q),
    .out_vld(out_vld), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
);

// File: tb/dqpsk_mapper_tb.sv
`timescale 1ns/1ps
module dqpsk_mapper_tb;
    localparam int A = 23170;
    localparam int D = 16383;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, sym_stb = 1'b0, bypass = 1'b0, byp_wr = 1'b0;
    logic [15:0] wr_data = '0;
    logic signed [15:0] byp_i = '0, byp_q = '0;
    logic signed [15:0] out_i, out_q;
    logic out_vld, fifo_full, fifo_empty, ovf_flag, unf_flag;

    int total = 0, bad = 0;
    bit done = 1'b0;

    typedef struct { int i; int q; string tag; } exp_t;
    exp_t exp_q[$];

    // Bench model state, kept from the requirements only.
    logic [15:0] m_words[$];
    int m_idx = 0;
    int m_ph = 0;

    always #10 clk = ~clk;

    dqpsk_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .sym_stb(sym_stb), .bypass(bypass), .byp_wr(byp_wr), .byp_i(byp_i),
        .byp_q(byp_q), .out_i(out_i), .out_q(out_q), .out_vld(out_vld),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic void point(input int k, output int pi, output int pq);
        case (k)
            0: begin pi = A;  pq = 0;  end
            1: begin pi = D;  pq = D;  end
            2: begin pi = 0;  pq = A;  end
            3: begin pi = -D; pq = D;  end
            4: begin pi = -A; pq = 0;  end
            5: begin pi = -D; pq = -D; end
            6: begin pi = 0;  pq = -A; end
            default: begin pi = D; pq = -D; end
        endcase
    endfunction

    task automatic write_word(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        if (m_words.size() < 4) m_words.push_back(w);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: one strobe; pushes the expected point unless in bypass.
    task automatic strobe(input string tag);
        exp_t e;
        int step;
        logic [1:0] d;
        @(negedge clk);
        sym_stb = 1'b1;
        if (!bypass) begin
            if (m_words.size() > 0) begin
                d = m_words[0][15 - 2*m_idx -: 2];
                case (d)
                    2'b00: step = 1;
                    2'b01: step = 3;
                    2'b10: step = 7;
                    default: step = 5;
                endcase
                m_ph = (m_ph + step) % 8;
                m_idx++;
                if (m_idx == 8) begin m_idx = 0; void'(m_words.pop_front()); end
            end
            point(m_ph, e.i, e.q);
            e.tag = tag;
            exp_q.push_back(e);
        end
        @(negedge clk);
        sym_stb = 1'b0;
    endtask

    task automatic direct(input int vi, input int vq);
        exp_t e;
        @(negedge clk);
        byp_wr = 1'b1; byp_i = 16'(vi); byp_q = 16'(vq);
        if (bypass) begin
            e.i = vi; e.q = vq; e.tag = "R9";
            exp_q.push_back(e);
        end
        @(negedge clk);
        byp_wr = 1'b0;
    endtask

    // Monitor: compare every valid output with the scoreboard head.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && out_vld && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected out_vld", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk(int'(out_i) == e.i, e.tag, "out_i", int'(out_i), e.i);
                chk(int'(out_q) == e.q, e.tag, "out_q", int'(out_q), e.q);
            end
        end
    end

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_vld == 1'b0, "R1", "out_vld", int'(out_vld), 0);
        chk(out_i == 16'sd0 && out_q == 16'sd0, "R1", "out zero", int'(out_i), 0);
        chk(fifo_empty && !fifo_full, "R1", "empty", int'(fifo_empty), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ovf_flag && !unf_flag, "R1", "flags", int'({ovf_flag, unf_flag}), 0);

        // R1/R2/R3/R4: first word 00 01 10 11 x2 walks phase 1,4,3,0
        write_word(16'h1B1B);
        chk(!fifo_empty, "R2", "not empty after write", int'(fifo_empty), 0);
        for (int k = 0; k < 7; k++) strobe("R3");
        chk(!fifo_empty, "R2", "word kept before 8th dibit", int'(fifo_empty), 0);
        strobe("R2");
        chk(fifo_empty, "R2", "word freed after 8th dibit", int'(fifo_empty), 1);

        // R11: direct write ignored with bypass low
        direct(123, -456);
        @(negedge clk);
        chk(out_i != 16'sd123, "R11", "out_i untouched", int'(out_i), 0);

        // R6/R7: fill, then overflow
        write_word(16'hA5C3);
        write_word(16'h0FF0);
        write_word(16'hFFFF);
        chk(!fifo_full, "R6", "3 words not full", int'(fifo_full), 0);
        write_word(16'h0000);
        chk(fifo_full, "R6", "4 words full", int'(fifo_full), 1);
        chk(!ovf_flag, "R7", "no ovf yet", int'(ovf_flag), 0);
        write_word(16'h5555);
        chk(ovf_flag, "R7", "ovf set", int'(ovf_flag), 1);

        // R9/R10: bypass passes direct data, strobes ignored
        @(negedge clk); bypass = 1'b1;
        direct(-1000, 2000);
        direct(32767, -32768);
        for (int k = 0; k < 3; k++) begin
            strobe("R10");
            chk(out_vld == 1'b0, "R10", "no vld in bypass", int'(out_vld), 0);
        end
        chk(fifo_full && !unf_flag, "R10", "no pop/underflow", int'(unf_flag), 0);
        @(negedge clk); bypass = 1'b0;

        // R5/R3/R4: drain all four words; phase continues from held value
        for (int k = 0; k < 32; k++) strobe("R3");
        chk(fifo_empty, "R6", "empty after drain", int'(fifo_empty), 1);
        chk(ovf_flag, "R7", "ovf sticky", int'(ovf_flag), 1);

        // R8: underflow repeats point and sets sticky flag
        strobe("R8");
        chk(unf_flag, "R8", "unf set", int'(unf_flag), 1);
        strobe("R8");
        write_word(16'h4000);
        chk(unf_flag, "R8", "unf sticky", int'(unf_flag), 1);
        for (int k = 0; k < 2; k++) strobe("R3");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule